// File: doc/BRIEF.md
# Dual-Slot Card Event Interrupt Controller

This block is the digital control core of a reader that serves two card slots from one serial host port. It watches a card-detect line and an overload flag for each slot, holds a two-bit supply-voltage code per slot, and drives one shared active-low interrupt line. The host talks to it over a four-wire SPI link (mode 0, 8-bit frames, MSB first). Each frame selects one slot with an address bit and writes that slot's supply code. Writing the supply code is also how the host acknowledges a slot's pending event.

An insertion needs a nonzero supply code before the interrupt clears. An extraction or an overload needs a zero code. On an extraction or overload the block forces the slot's code to zero itself, and on an extraction it also issues a one-cycle power-down request. To find out which slot raised the interrupt, the host polls: every frame shifts out a status byte for the slot addressed by the previous frame, captured before that frame's write took effect. All SPI inputs and the card event inputs pass through two-flop synchronizers into the system clock domain.

Top module: `dual_card_event_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `irq_n` is 1, both supply codes are 00, `pwr_down` is 00 and `spi_miso` is 0.
- R2: A frame whose bit 7 is 1 changes no state. Otherwise bit 5 picks the slot (0 = A, 1 = B), bit 6 is ignored, and bits 1..0 become that slot's supply code (00 = off, 01/10/11 = powered).
- R3: A rising `card_det` on either slot pulls `irq_n` low.
- R4: A falling `card_det` pulls `irq_n` low, forces that slot's code to 00, and raises that slot's `pwr_down` bit for exactly one clock.
- R5: A rising `ovld` forces that slot's code to 00, latches that slot's overload flag and pulls `irq_n` low.
- R6: A pending insertion is cleared only by a nonzero code written to that slot. A 00 write leaves it pending.
- R7: A pending extraction or overload is cleared only by a 00 write to that slot. A nonzero write leaves it pending.
- R8: If a card is pulled and re-inserted before acknowledgement, `irq_n` stays low throughout, and the pending event then needs a nonzero write.
- R9: While `spi_cs_n` is high, clock and data activity on the SPI pins changes no register, and `spi_miso` is 0.
- R10: Each frame shifts out on `spi_miso`, MSB first, the status of the slot addressed by the previous frame as it was before that frame's write. Bit 7 is pending, bit 6 is card present, bit 5 is overload latched, bits 1..0 are the supply code, and the other bits are 0. After a frame with bit 7 set, the next readback is 0x00.
- R11: `irq_n` is low while either slot has a pending event and returns high only when both are cleared.
- R12: The latched overload flag of a slot is cleared by a nonzero code write to that slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from host |
| spi_miso | output | 1 | SPI data to host, 0 when deselected |
| card_det | input | 2 | Card detect per slot, bit 0 = A, bit 1 = B |
| ovld | input | 2 | Overload flag per slot |
| irq_n | output | 1 | Shared interrupt, active low |
| supply_code | output | 4 | Supply codes, [1:0] = slot A, [3:2] = slot B |
| pwr_down | output | 2 | One-cycle power-down request per slot |

## Verification
The hardest state to reach is a slot whose pending event has changed kind before acknowledgement. One case is an extraction followed by a re-insertion. Another is an overload after a card sits powered. In both, the correct acknowledgement code is the opposite of what the previous event wanted. The stimulus drives the card-detect and overload lines between complete SPI frames. It then issues the wrong acknowledgement first and the right one second. Because readback is delayed by one frame, each status byte is checked against the value expected before the previous write, and the cycle-level reference model tracks the synchronizer delay of every input.

// File: rtl/dce_pkg.sv
package dce_pkg;
  localparam int FRAME_W   = 8;
  localparam int CODE_W    = 2;
  localparam int SLOTS     = 2;
  localparam int SYNC_DEPTH = 2;
  // command decode positions
  localparam int CMD_IGNORE_BIT = 7;
  localparam int CMD_SLOT_BIT   = 5;

  typedef struct packed {
    logic              pending;
    logic              present;
    logic              ovl_seen;
    logic [2:0]        zero;
    logic [CODE_W-1:0] code;
  } slot_status_t;

  function automatic slot_status_t make_status(
    input logic pending, input logic present, input logic ovl_seen,
    input logic [CODE_W-1:0] code);
    slot_status_t s;
    s.pending  = pending;
    s.present  = present;
    s.ovl_seen = ovl_seen;
    s.zero     = 3'b000;
    s.code     = code;
    return s;
  endfunction
endpackage

// File: rtl/dce_sync.sv
module dce_sync #(
  parameter int             W      = 1,
  parameter int             DEPTH  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[DEPTH-1];
endmodule

// File: rtl/dce_spi_frame.sv
module dce_spi_frame #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               cs_n_s,
  input  logic               mosi_s,
  input  logic               tx_load,
  input  logic [FRAME_W-1:0] tx_byte,
  output logic               frame_valid,
  output logic [FRAME_W-1:0] frame_byte,
  output logic               miso
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic               sclk_q;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] rx_q, rx_d, tx_q, tx_d, rx_shift;
  logic               rise, fall, rx_en, tx_en;

  always_comb begin
    rise     = ~cs_n_s & sclk_s & ~sclk_q;
    fall     = ~cs_n_s & ~sclk_s & sclk_q;
    rx_shift = {rx_q[FRAME_W-2:0], mosi_s};
    rx_en    = rise;
    rx_d     = rx_shift;
    cnt_d    = cnt_q;
    if (cs_n_s)    cnt_d = '0;
    else if (rise) cnt_d = (cnt_q == LAST_BIT) ? '0 : cnt_q + 1'b1;
    // no shift on the falling edge that follows the last sampled bit
    tx_en = tx_load | (fall & (cnt_q != '0));
    tx_d  = tx_load ? tx_byte : {tx_q[FRAME_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
    end else begin
      sclk_q <= sclk_s;
      cnt_q  <= cnt_d;
      if (rx_en) rx_q <= rx_d;
      if (tx_en) tx_q <= tx_d;
    end
  end

  assign frame_valid = rise & (cnt_q == LAST_BIT);
  assign frame_byte  = rx_shift;
  assign miso        = tx_q[FRAME_W-1] & ~cs_n_s;
endmodule

// File: rtl/dce_slot.sv
module dce_slot
  import dce_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              det_s,
  input  logic              ovl_s,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  output logic              pending,
  output logic              ovl_seen,
  output logic [CODE_W-1:0] code,
  output logic              pwr_down
);
  logic              det_q, ovl_q;
  logic              pend_q, pend_d, want_nz_q, want_nz_d;
  logic              ovl_lat_q, ovl_lat_d, pd_q, pd_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              ins, rem, ovr, force_off, wr_nz;

  always_comb begin
    ins       = det_s & ~det_q;
    rem       = ~det_s & det_q;
    ovr       = ovl_s & ~ovl_q;
    force_off = rem | ovr;
    wr_nz     = |wr_code;

    code_d = code_q;
    if (wr_en)     code_d = wr_code;
    if (force_off) code_d = '0;

    pend_d    = pend_q;
    want_nz_d = want_nz_q;
    if (ins | force_off) begin
      pend_d    = 1'b1;
      want_nz_d = ins & ~force_off;
    end else if (wr_en && pend_q && (wr_nz == want_nz_q)) begin
      pend_d = 1'b0;
    end

    ovl_lat_d = ovl_lat_q;
    if (ovr)                ovl_lat_d = 1'b1;
    else if (wr_en && wr_nz) ovl_lat_d = 1'b0;

    pd_d = rem;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q     <= 1'b0;
      ovl_q     <= 1'b0;
      pend_q    <= 1'b0;
      want_nz_q <= 1'b0;
      ovl_lat_q <= 1'b0;
      code_q    <= '0;
      pd_q      <= 1'b0;
    end else begin
      det_q     <= det_s;
      ovl_q     <= ovl_s;
      pend_q    <= pend_d;
      want_nz_q <= want_nz_d;
      ovl_lat_q <= ovl_lat_d;
      code_q    <= code_d;
      pd_q      <= pd_d;
    end
  end

  assign pending  = pend_q;
  assign ovl_seen = ovl_lat_q;
  assign code     = code_q;
  assign pwr_down = pd_q;
endmodule

// File: rtl/dual_card_event_ctrl.sv
module dual_card_event_ctrl
  import dce_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     spi_sclk,
  input  logic                     spi_cs_n,
  input  logic                     spi_mosi,
  output logic                     spi_miso,
  input  logic [SLOTS-1:0]         card_det,
  input  logic [SLOTS-1:0]         ovld,
  output logic                     irq_n,
  output logic [SLOTS*CODE_W-1:0]  supply_code,
  output logic [SLOTS-1:0]         pwr_down
);
  localparam int EVT_W = 2 * SLOTS;

  logic [2:0]         spi_s;
  logic [EVT_W-1:0]   evt_s;
  logic               frame_valid;
  logic [FRAME_W-1:0] frame_byte, tx_byte;
  logic               cmd_ok;
  logic               cmd_slot;
  logic [SLOTS-1:0]   pend;
  slot_status_t       stat [SLOTS];

  // {sclk, cs_n, mosi}; chip select resets to deselected
  dce_sync #(.W(3), .DEPTH(SYNC_DEPTH), .RST_VAL(3'b010)) u_spi_sync (
    .clk(clk), .rst_n(rst_n), .d({spi_sclk, spi_cs_n, spi_mosi}), .q(spi_s));

  dce_sync #(.W(EVT_W), .DEPTH(SYNC_DEPTH), .RST_VAL('0)) u_evt_sync (
    .clk(clk), .rst_n(rst_n), .d({ovld, card_det}), .q(evt_s));

  dce_spi_frame #(.FRAME_W(FRAME_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(spi_s[2]), .cs_n_s(spi_s[1]), .mosi_s(spi_s[0]),
    .tx_load(frame_valid), .tx_byte(tx_byte),
    .frame_valid(frame_valid), .frame_byte(frame_byte), .miso(spi_miso));

  assign cmd_ok   = ~frame_byte[CMD_IGNORE_BIT];
  assign cmd_slot = frame_byte[CMD_SLOT_BIT];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic              wr_en, ovl_seen;
    logic [CODE_W-1:0] code;
    assign wr_en = frame_valid & cmd_ok & (cmd_slot == 1'(i));
    dce_slot u_slot (
      .clk(clk), .rst_n(rst_n),
      .det_s(evt_s[i]), .ovl_s(evt_s[SLOTS+i]),
      .wr_en(wr_en), .wr_code(frame_byte[CODE_W-1:0]),
      .pending(pend[i]), .ovl_seen(ovl_seen), .code(code),
      .pwr_down(pwr_down[i]));
    assign stat[i] = make_status(pend[i], evt_s[i], ovl_seen, code);
    assign supply_code[i*CODE_W +: CODE_W] = code;
  end

  // snapshot taken in the same cycle as the write, so it holds pre-write state
  always_comb begin
    if (!cmd_ok) tx_byte = '0;
    else         tx_byte = stat[cmd_slot];
  end

  assign irq_n = ~|pend;
endmodule

// File: rtl/dce_checker.sv
module dce_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_cs_n,
  input logic       spi_miso,
  input logic       irq_n,
  input logic [3:0] supply_code,
  input logic [1:0] pwr_down
);
  always_comb begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (irq_n && supply_code == 4'b0 && pwr_down == 2'b0 && !spi_miso)
        else $error("R1 reset outputs not idle");
    end
  end

  assert_pd_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down[0] |=> !pwr_down[0]);

  assert_pd_single_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down[1] |=> !pwr_down[1]);

  assert_pd_code_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down[0] |-> supply_code[1:0] == 2'b00);

  assert_powerup_needs_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_code[1:0] != $past(supply_code[1:0]) && supply_code[1:0] != 2'b00)
      |-> !$past(spi_cs_n, 3));

  assert_miso_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(spi_cs_n) && $past(spi_cs_n, 2)) |-> !spi_miso);
endmodule

bind dual_card_event_ctrl dce_checker u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
  .irq_n(irq_n), .supply_code(supply_code), .pwr_down(pwr_down));

// File: tb/dual_card_event_ctrl_tb_top.sv
module dual_card_event_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic [1:0] det = 2'b00, ovl = 2'b00;
  logic       miso, irq_n;
  logic [3:0] supply;
  logic [1:0] pd;

  int checks = 0, errors = 0;
  int pd_cnt_a = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  dual_card_event_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .card_det(det), .ovld(ovl), .irq_n(irq_n),
    .supply_code(supply), .pwr_down(pd));

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // inputs seen after two sampling stages, plus the value one cycle older
  bit [6:0] st1, st2;                 // {sclk, cs_n, mosi, ovl[1:0], det[1:0]}
  bit       p_sclk;
  bit [1:0] p_det, p_ovl;
  bit [1:0] m_pend, m_wnz, m_olat, m_pd;
  bit [1:0] m_code [2];
  int       m_cnt;
  bit [7:0] m_rx, m_tx;

  function automatic bit [7:0] m_status(input int s, input bit present);
    return {m_pend[s], present, m_olat[s], 3'b000, m_code[s]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1 = 7'b0100000; st2 = 7'b0100000;
      p_sclk = 0; p_det = 0; p_ovl = 0;
      m_pend = 0; m_wnz = 0; m_olat = 0; m_pd = 0;
      m_code[0] = 0; m_code[1] = 0;
      m_cnt = 0; m_rx = 0; m_tx = 0;
    end else begin
      bit s_sclk, s_cs, s_mosi, rise, fall, frame_end;
      bit [7:0] byte_in, snap;
      s_sclk = st2[6]; s_cs = st2[5]; s_mosi = st2[4];
      rise = !s_cs && s_sclk && !p_sclk;
      fall = !s_cs && !s_sclk && p_sclk;
      byte_in = {m_rx[6:0], s_mosi};
      frame_end = rise && (m_cnt == 7);
      snap = 8'h00;
      if (frame_end && !byte_in[7]) snap = m_status(int'(byte_in[5]), st2[int'(byte_in[5])]);
      for (int s = 0; s < 2; s++) begin
        bit ins, rem, ov, wr, nz;
        ins = st2[s] && !p_det[s];
        rem = !st2[s] && p_det[s];
        ov  = st2[2+s] && !p_ovl[s];
        wr  = frame_end && !byte_in[7] && (int'(byte_in[5]) == s);
        nz  = byte_in[1:0] != 2'b00;
        if (ins || rem || ov) begin
          m_pend[s] = 1; m_wnz[s] = ins && !(rem || ov);
        end else if (wr && m_pend[s] && (nz == m_wnz[s])) m_pend[s] = 0;
        if (ov) m_olat[s] = 1; else if (wr && nz) m_olat[s] = 0;
        if (rem || ov) m_code[s] = 0; else if (wr) m_code[s] = byte_in[1:0];
        m_pd[s] = rem;
      end
      if (frame_end) m_tx = snap;
      else if (fall && m_cnt != 0) m_tx = m_tx << 1;
      if (s_cs) m_cnt = 0;
      else if (rise) begin m_rx = byte_in; m_cnt = (m_cnt + 1) % 8; end
      p_sclk = s_sclk; p_det = st2[1:0]; p_ovl = st2[3:2];
      st2 = st1;
      st1 = {sclk, cs_n, mosi, ovl, det};
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      check("R11", "irq_n vs model", int'(irq_n), int'(!(m_pend[0] || m_pend[1])));
      check("R2",  "supply vs model", int'(supply), int'({m_code[1], m_code[0]}));
      check("R4",  "pwr_down vs model", int'(pd), int'(m_pd));
      check("R10", "miso vs model", int'(miso), int'(m_tx[7] && !st2[5]));
      if (pd[0]) pd_cnt_a++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input bit [7:0] tx, output bit [7:0] rx);
    cs_n = 1'b0;
    wait_clk(6);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      wait_clk(6);
      rx[b] = miso;
      sclk = 1'b1;
      wait_clk(6);
      sclk = 1'b0;
    end
    wait_clk(6);
    cs_n = 1'b1;
    wait_clk(6);
  endtask

  task automatic xfer(input string req, input bit [7:0] tx, input bit [7:0] exp_rx);
    bit [7:0] rx;
    frame(tx, rx);
    check(req, "readback", int'(rx), int'(exp_rx));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit [3:0] sup_before;
    wait_clk(5);
    check("R1", "irq_n in reset", int'(irq_n), 1);
    check("R1", "supply in reset", int'(supply), 0);
    rst_n = 1'b1;
    wait_clk(4);
    check("R1", "pwr_down after reset", int'(pd), 0);

    // R2 decode and R10 delayed readback
    xfer("R10", 8'h01, 8'h00);
    check("R2", "slot A code 01", int'(supply[1:0]), 1);
    xfer("R2", 8'h62, 8'h00);                 // bit6 set, slot B
    check("R2", "slot B code 10 with b6 set", int'(supply[3:2]), 2);
    xfer("R2", 8'h83, 8'h00);                 // ignored frame
    check("R2", "ignored frame keeps A", int'(supply[1:0]), 1);
    xfer("R10", 8'h20, 8'h00);                // after ignored frame readback is zero
    check("R2", "slot B code 00", int'(supply[3:2]), 0);

    // R3 / R6 insertion
    det[0] = 1'b1; wait_clk(10);
    check("R3", "irq after insertion", int'(irq_n), 0);
    xfer("R10", 8'h00, 8'h02);
    check("R6", "zero write keeps insertion pending", int'(irq_n), 0);
    xfer("R10", 8'h03, 8'hC1);
    check("R6", "nonzero write clears", int'(irq_n), 1);
    check("R2", "slot A code 11", int'(supply[1:0]), 3);

    // R5 / R7 / R12 overload
    ovl[0] = 1'b1; wait_clk(10);
    check("R5", "overload forces code 00", int'(supply[1:0]), 0);
    check("R5", "irq after overload", int'(irq_n), 0);
    ovl[0] = 1'b0; wait_clk(4);
    xfer("R10", 8'h02, 8'hC0);
    check("R7", "nonzero write keeps overload pending", int'(irq_n), 0);
    xfer("R5", 8'h00, 8'hE0);                 // overload latched seen
    check("R7", "zero write clears overload", int'(irq_n), 1);
    xfer("R12", 8'h20, 8'hC2);                // latch cleared by the 10 write

    // R4 extraction, R8 re-insertion
    xfer("R10", 8'h01, 8'h00);
    check("R2", "slot A code 01 again", int'(supply[1:0]), 1);
    pd_cnt_a = 0;
    det[0] = 1'b0; wait_clk(10);
    check("R4", "extraction forces 00", int'(supply[1:0]), 0);
    check("R4", "one power-down pulse", pd_cnt_a, 1);
    check("R4", "irq after extraction", int'(irq_n), 0);
    det[0] = 1'b1; wait_clk(10);
    check("R8", "irq stays low on re-insert", int'(irq_n), 0);
    xfer("R10", 8'h00, 8'h40);
    check("R8", "zero write no longer clears", int'(irq_n), 0);
    xfer("R8", 8'h01, 8'hC0);
    check("R8", "nonzero write clears", int'(irq_n), 1);

    // R11 both slots pending
    det[1] = 1'b1; wait_clk(4);
    ovl[0] = 1'b1; wait_clk(10); ovl[0] = 1'b0; wait_clk(4);
    check("R11", "two pending", int'(irq_n), 0);
    xfer("R11", 8'h21, 8'hC0);
    check("R11", "A still pending holds irq", int'(irq_n), 0);
    xfer("R11", 8'h00, 8'hC0);
    check("R11", "both cleared", int'(irq_n), 1);

    // R9 deselected activity is ignored
    sup_before = supply;
    mosi = 1'b1;
    for (int k = 0; k < 16; k++) begin
      sclk = 1'b1; wait_clk(5);
      check("R9", "miso quiet", int'(miso), 0);
      sclk = 1'b0; wait_clk(5);
    end
    check("R9", "supply unchanged", int'(supply), int'(sup_before));
    check("R9", "irq unchanged", int'(irq_n), 1);
    xfer("R9", 8'h20, 8'hE0);

    wait_clk(4);
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule